// File: doc/BRIEF.md
# Second-Order Digital Noise-Shaping Modulator with Selectable Band

This block takes a stream of wide signed samples and reduces each one to a level code from 0 to 4. The code is the number of equal unit cells to switch on in a four-cell current DAC. Two saturating integrators are cascaded inside a feedback loop. The quantized code is subtracted back into both integrators, so the coarse output follows the fine input on average. The rounding error is pushed out of the band of interest.

A mode bit selects the band.
- In lowpass mode the loop suppresses quantization noise near DC.
- In highpass mode the signs in the feedback summations are reversed. Noise is then suppressed near half the sample rate, and signals are expected to sit close to that frequency.

The mode is latched only while reset is asserted, so a running loop never sees a sign change.

The input scale is fixed: one output level equals 2^F input LSBs. A zero input is centred on the mid code 2. The loop is meant to follow a sine of 1.7 levels amplitude around that centre.

Top module: `dsm2_mod`

## Requirements
- R1: While reset is held, the output code is 0 and out_valid is 0. Both integrators and the latched mode are cleared or captured, so that the first valid sample after reset starts from zero integrator state and a feedback value of 0.
- R2: A constant zero input settles at once to code 2 in either mode. From reset, every output for a zero input is 2.
- R3: Lowpass mode (hp_mode latched as 0). Let u = din + 2·2^F and y = previous code·2^F. Each valid sample computes A = sat(A + u − y), then B = sat(B + A_new − y).
- R4: Highpass mode (hp_mode latched as 1). Each valid sample computes A = sat(u + y − A), then B = sat(A_new + y − B).
- R5: The output code is floor((B_new + 2^(F−1)) / 2^F), clamped to the range 0 to 4. The code is an unsigned 3-bit value on the code port.
- R6: Both integrators are W+G bits wide and signed. Results outside that range saturate to the most positive or most negative value and never wrap. As a result, a long overdrive followed by a negative step keeps the code at 4 for several samples.
- R7: hp_mode is sampled only while reset is asserted. A change of hp_mode after reset has no effect on any output until the next reset.
- R8: For each sample with in_valid high, the new code and out_valid high appear at the first rising edge. A cycle without in_valid drives out_valid low and leaves the code and both integrators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| din | input | W | Signed input sample, 2^F LSBs per output level |
| hp_mode | input | 1 | 0 selects lowpass shaping, 1 selects highpass; latched during reset |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| code | output | 3 | Number of unit cells to switch on, 0 to 4 |

## Verification
Several lowpass patterns were worked out by hand and set against the recurrences of R3 and R5:
- a half-level DC offset, which exposes the alternation between codes 2 and 3;
- a full negative step and a full positive step, which probe the clamp at both ends;
- a one-level step, which shows settling.

A short highpass sequence from reset separates the reversed signs of R4 from the lowpass signs.

Sines of 1.7 levels amplitude are then applied: one near DC in lowpass mode and one near half the sample rate in highpass mode. Each output is compared with an integer model of the requirements. During these runs hp_mode is toggled after reset, which shows that the latched mode alone decides the band.

A long full-scale overdrive followed by a negative step tells saturating integrators apart from wrapping ones.

// File: rtl/dsm2_mod.sv
module dsm2_mod #(
  parameter int W = 16,
  parameter int F = 12,
  parameter int G = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] din,
  input  logic                hp_mode,
  output logic                out_valid,
  output logic [2:0]          code
);
  localparam int AW = W + G;
  localparam int EW = AW + 2;
  localparam logic signed [EW-1:0] HI   = EW'((1 << (AW-1)) - 1);
  localparam logic signed [EW-1:0] LO   = -EW'(1 << (AW-1));
  localparam logic signed [EW-1:0] MID  = EW'(2 << F);
  localparam logic signed [EW-1:0] HALF = EW'(1 << (F-1));

  logic signed [AW-1:0] i1_q, i2_q;
  logic [2:0]           code_q;
  logic                 mode_q, ov_q;

  logic signed [EW-1:0] u, fb, i1x, i2x, s1, s2, n1x, r, qv;
  logic signed [AW-1:0] n1, n2;
  logic [2:0]           qc;

  function automatic logic signed [AW-1:0] sat(input logic signed [EW-1:0] v);
    if (v > HI)      return HI[AW-1:0];
    else if (v < LO) return LO[AW-1:0];
    else             return v[AW-1:0];
  endfunction

  assign u   = {{(EW-W){din[W-1]}}, din} + MID;
  assign fb  = EW'({code_q, {F{1'b0}}});
  assign i1x = {{(EW-AW){i1_q[AW-1]}}, i1_q};
  assign i2x = {{(EW-AW){i2_q[AW-1]}}, i2_q};
  assign s1  = mode_q ? (u + fb - i1x) : (i1x + u - fb);
  assign n1  = sat(s1);
  assign n1x = {{(EW-AW){n1[AW-1]}}, n1};
  assign s2  = mode_q ? (n1x + fb - i2x) : (i2x + n1x - fb);
  assign n2  = sat(s2);
  assign r   = {{(EW-AW){n2[AW-1]}}, n2} + HALF;
  assign qv  = r >>> F;

  always_comb begin
    if (qv < 0)      qc = 3'd0;
    else if (qv > 4) qc = 3'd4;
    else             qc = qv[2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i1_q   <= '0;
      i2_q   <= '0;
      code_q <= 3'd0;
      ov_q   <= 1'b0;
      mode_q <= hp_mode;
    end else begin
      ov_q <= in_valid;
      if (in_valid) begin
        i1_q   <= n1;
        i2_q   <= n2;
        code_q <= qc;
      end
    end
  end

  assign out_valid = ov_q;
  assign code      = code_q;
endmodule

// File: rtl/dsm2_chk.sv
module dsm2_chk #(
  parameter int AW = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [2:0]           code,
  input logic                 mode_q,
  input logic signed [AW-1:0] i1_q
);
  localparam logic signed [AW-1:0] QTR = AW'(1 << (AW-2));

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (code == 3'd0 && !out_valid));

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (rst) code <= 3'd4);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(code)));

  // R7
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> $stable(mode_q));

  // R6
  no_wrap_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_q && i1_q > QTR) |=> i1_q > 0);

  // R6
  no_wrap_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_q && i1_q < -QTR) |=> i1_q < 0);
endmodule

bind dsm2_mod dsm2_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .code(code), .mode_q(mode_q), .i1_q(i1_q)
);

// File: tb/tb_dsm2_mod.sv
module tb_dsm2_mod;
  localparam int W = 16, F = 12, G = 4;
  localparam int PERIOD = 10;
  localparam int L = 1 << F;
  localparam int AMAX = (1 << (W + G - 1)) - 1;
  localparam int AMIN = -(1 << (W + G - 1));

  logic clk = 0, rst = 1, in_valid = 0, hp_mode = 0;
  logic signed [W-1:0] din = '0;
  logic out_valid;
  logic [2:0] code;

  int checks = 0, fails = 0;
  int ma = 0, mb = 0, myp = 0, mmode = 0;
  bit done = 0;

  // Table: input in LSBs, expected code (lowpass, from reset). R3 R5
  localparam int VEC [14][2] = '{
    '{0, 2}, '{2048, 3}, '{2048, 2}, '{2048, 2}, '{2048, 3}, '{2048, 3}, '{2048, 2},
    '{-8192, 0}, '{-8192, 0}, '{8192, 4}, '{8192, 4}, '{8192, 4}, '{-4096, 1}, '{-4096, 1}};
  localparam int HPV [5][2] = '{'{0, 2}, '{2048, 3}, '{2048, 4}, '{2048, 4}, '{2048, 3}};

  dsm2_mod #(.W(W), .F(F), .G(G)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .din(din), .hp_mode(hp_mode),
    .out_valid(out_valid), .code(code));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int msat(input int v);
    return (v > AMAX) ? AMAX : (v < AMIN) ? AMIN : v;
  endfunction

  function automatic int mstep(input int x);
    int u, q;
    u = x + 2 * L;
    if (mmode == 0) begin
      ma = msat(ma + u - myp);
      mb = msat(mb + ma - myp);
    end else begin
      ma = msat(u + myp - ma);
      mb = msat(ma + myp - mb);
    end
    q = (mb + L / 2) >>> F;
    if (q < 0) q = 0;
    if (q > 4) q = 4;
    myp = q * L;
    return q;
  endfunction

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst = 1; in_valid = 0; hp_mode = m;
    repeat (3) @(posedge clk);
    #1;
    chk(code == 0, "R1 code", code, 0);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    @(negedge clk);
    rst = 0;
    ma = 0; mb = 0; myp = 0; mmode = m;
  endtask

  task automatic send(input int x, output int c);
    @(negedge clk);
    in_valid = 1; din = W'(x);
    @(posedge clk);
    #1;
    c = code;
    chk(out_valid == 1, "R8 out_valid", out_valid, 1);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int c, e, hold;
    // R1 reset, then R3/R5 table
    do_reset(0);
    foreach (VEC[i]) begin
      send(VEC[i][0], c);
      chk(c == VEC[i][1], "R3 R5 table", c, VEC[i][1]);
    end
    // R8 idle cycles keep code and state
    hold = code;
    idle();
    @(posedge clk); #1;
    chk(out_valid == 0, "R8 idle valid", out_valid, 0);
    chk(code == hold, "R8 idle hold", code, hold);
    @(posedge clk); #1;
    chk(code == hold, "R8 idle hold", code, hold);
    send(-4096, c);
    chk(c == 1, "R8 state kept", c, 1);
    idle();

    // R2 zero input both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int k = 0; k < 10; k++) begin
        send(0, c);
        chk(c == 2, "R2 zero input", c, 2);
      end
      idle();
    end

    // R4 hand sequence in highpass
    do_reset(1);
    foreach (HPV[i]) begin
      send(HPV[i][0], c);
      chk(c == HPV[i][1], "R4 hp sequence", c, HPV[i][1]);
    end
    idle();

    // R3 R7 lowpass sine of 1.7 levels, mode pin flipped after reset
    do_reset(0);
    hp_mode = 1;
    for (int n = 0; n < 400; n++) begin
      int x;
      x = int'(1.7 * L * $sin(2.0 * 3.14159265 * n / 200.0));
      e = mstep(x);
      send(x, c);
      chk(c == e, "R3 R7 lp sine", c, e);
    end
    idle();

    // R4 R7 highpass sine near half rate, mode pin cleared after reset
    do_reset(1);
    hp_mode = 0;
    for (int n = 0; n < 400; n++) begin
      int x;
      x = int'(1.7 * L * $cos(3.14159265 * n * (63.0 / 64.0)));
      e = mstep(x);
      send(x, c);
      chk(c == e, "R4 R7 hp sine", c, e);
    end
    idle();

    // R6 overdrive then negative step
    do_reset(0);
    for (int n = 0; n < 200; n++) begin
      e = mstep(32767);
      send(32767, c);
      chk(c == 4, "R6 overdrive", c, 4);
      chk(c == e, "R6 overdrive model", c, e);
    end
    for (int n = 0; n < 3; n++) begin
      e = mstep(-8192);
      send(-8192, c);
      chk(c == 4, "R6 saturated recovery", c, 4);
    end
    idle();
    @(posedge clk); #1;
    chk(out_valid == 0, "R8 final idle", out_valid, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule